// File: doc/BRIEF.md
# PCIe Root-Complex Address Window Decoder

This block sits in the address path of a PCIe root complex and sorts every address it is given into one of two directions. An address that falls in one of the outbound windows goes downstream to the link, translated into PCIe space. An address that falls in the inbound viewport, or in one of two auxiliary inbound windows, goes upstream to system memory, translated to an offset from the start of that region. The inbound viewport may overlap the outbound windows. Where they overlap, the outbound window always wins.

Configuration arrives through three simple write ports: one for the viewport, one for the auxiliary windows and one for the outbound windows. When the viewport is written, the block works out its power-of-two size from the span, checks where it is placed, and reports both a configuration error flag and the encoded size field a memory-side register would hold. Each lookup returns its result one cycle after it is presented: a valid strobe, a hit flag, an error flag, the direction and the translated address.

Top module: `pcie_addr_window_dec`

## Requirements
- R1: `res_vld_o` is high exactly in the cycle after a cycle with `addr_vld_i` high. While `res_vld_o` is low, `res_hit_o`, `res_err_o`, `res_dir_o` and `res_xlat_o` are all zero.
- R2: An enabled outbound window covers CPU addresses from `ob_cpu_start_i` to `ob_cpu_end_i`, both ends included. An address in it returns hit=1 and dir=1 (downstream), with translated address = address − cpu_start + pci_start.
- R3: When outbound windows overlap, the window with the lowest index supplies the result.
- R4: An address inside both an outbound window and the inbound viewport is routed downstream (dir=1) with the outbound translation.
- R5: A viewport write sets the size to 2^n, where n is the 1-based position of the highest set bit of `ib_span_i`. A valid viewport maps [base, base+size). An address there that no outbound window claims returns hit=1, dir=0 and translated address = address − base.
- R6: `ib_size_fld_o` reads 0xF after reset and after any rejected viewport write. After an accepted write it reads n − 15.
- R7: A viewport write is rejected (`ib_cfg_err_o`=1, viewport disabled) when n equals the address width, because the size overflows to zero. It is also rejected when n < 15, because the size cannot be encoded.
- R8: A viewport write whose base is not a multiple of its size is rejected.
- R9: A viewport write whose base is strictly between 0x8000_0000 and 0x1_0000_0000 is rejected. Bases of exactly 0x8000_0000 and 0x1_0000_0000 are allowed.
- R10: The two auxiliary inbound windows come out of reset with a size field of 0, which means disabled. A field f ≠ 0 maps the 2^(f+15)-byte block that contains the base; its low base bits are ignored. A hit returns dir=0 and the offset within that block. Auxiliary windows rank below the main viewport.
- R11: An outbound write with `ob_idx_i` ≥ 4 changes no window and sets the sticky flag `ob_ovf_o`, which only reset clears.
- R12: A lookup that no window claims returns hit=0, err=1, dir=0 and translated address 0.
- R13: An outbound window whose length (end − start + 1) is zero is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ib_wr_i | input | 1 | Viewport write strobe |
| ib_base_i | input | 64 | Viewport base in PCIe space |
| ib_span_i | input | 64 | Viewport span (end − start) |
| aux_wr_i | input | 1 | Auxiliary window write strobe |
| aux_idx_i | input | 1 | Auxiliary window index |
| aux_base_i | input | 64 | Auxiliary window base |
| aux_fld_i | input | 6 | Auxiliary window size field, 0 = disabled |
| ob_wr_i | input | 1 | Outbound window write strobe |
| ob_idx_i | input | 3 | Outbound window index |
| ob_cpu_start_i | input | 64 | Outbound window CPU start |
| ob_cpu_end_i | input | 64 | Outbound window CPU end (inclusive) |
| ob_pci_start_i | input | 64 | Outbound window PCIe start |
| addr_vld_i | input | 1 | Lookup request |
| addr_i | input | 64 | Lookup address |
| res_vld_o | output | 1 | Lookup result valid |
| res_hit_o | output | 1 | A window claimed the address |
| res_err_o | output | 1 | No window claimed the address |
| res_dir_o | output | 1 | 1 = downstream, 0 = upstream |
| res_xlat_o | output | 64 | Translated address |
| ib_cfg_err_o | output | 1 | Last viewport write was rejected |
| ib_size_fld_o | output | 6 | Encoded viewport size field |
| ob_ovf_o | output | 1 | Outbound index overflow, sticky |

## Verification
A lookup result is due on the first rising edge after `addr_vld_i` is sampled high. The status outputs of a write, meaning the error flag, the size field and the overflow flag, are likewise due one edge after the write strobe. The bench drives every request and write on a falling edge, lets exactly one rising edge pass, and reads the outputs on the following falling edge. Each result is therefore checked in its due cycle, and the valid strobe is checked to drop one edge later.

// File: rtl/addr_win_pkg.sv
`timescale 1ns/1ps
package addr_win_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
  localparam int unsigned UNCFG_FLD = 15;
endpackage

// File: rtl/vp_cfg.sv
`timescale 1ns/1ps
module vp_cfg #(
  parameter int AW       = 64,
  parameter int SFW      = 6,
  parameter int MIN_LOG2 = 15,
  parameter int N_AUX    = 2,
  localparam int LW      = $clog2(AW + 1),
  localparam int AUXW    = (N_AUX > 1) ? $clog2(N_AUX) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ib_wr_i,
  input  logic [AW-1:0]   ib_base_i,
  input  logic [AW-1:0]   ib_span_i,
  input  logic            aux_wr_i,
  input  logic [AUXW-1:0] aux_idx_i,
  input  logic [AW-1:0]   aux_base_i,
  input  logic [SFW-1:0]  aux_fld_i,
  output logic            vp_en_o,
  output logic [AW-1:0]   vp_base_o,
  output logic [LW-1:0]   vp_log2_o,
  output logic            cfg_err_o,
  output logic [SFW-1:0]  size_fld_o,
  output logic [AW-1:0]   aux_base_o [N_AUX],
  output logic [SFW-1:0]  aux_fld_o  [N_AUX]
);
  import addr_win_pkg::*;

  localparam logic [AW-1:0] FORBID_LO = AW'(64'h0000_0000_8000_0000);
  localparam logic [AW-1:0] FORBID_HI = AW'(64'h0000_0001_0000_0000);

  logic [LW-1:0]  span_fls;
  logic [AW-1:0]  low_mask;
  logic           size_zero, too_small, misalign, forbidden, bad;
  logic [SFW-1:0] new_fld;

  // position of highest set bit, 1-based
  always_comb begin
    span_fls = '0;
    for (int i = 0; i < AW; i++)
      if (ib_span_i[i]) span_fls = LW'(i + 1);
  end

  always_comb begin
    size_zero = (span_fls == LW'(AW));
    too_small = (span_fls < LW'(MIN_LOG2));
    low_mask  = (AW'(1) << span_fls) - AW'(1);
    misalign  = |(ib_base_i & low_mask);
    forbidden = (ib_base_i > FORBID_LO) && (ib_base_i < FORBID_HI);
    bad       = size_zero | too_small | misalign | forbidden;
    new_fld   = bad ? SFW'(UNCFG_FLD) : SFW'(span_fls - LW'(MIN_LOG2));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vp_en_o    <= 1'b0;
      vp_base_o  <= '0;
      vp_log2_o  <= '0;
      cfg_err_o  <= 1'b0;
      size_fld_o <= SFW'(UNCFG_FLD);
    end else if (ib_wr_i) begin
      vp_en_o    <= !bad;
      vp_base_o  <= ib_base_i;
      vp_log2_o  <= span_fls;
      cfg_err_o  <= bad;
      size_fld_o <= new_fld;
    end
  end

  for (genvar g = 0; g < N_AUX; g++) begin : g_aux
    logic [AW-1:0]  base_q;
    logic [SFW-1:0] fld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        fld_q  <= '0;
      end else if (aux_wr_i && aux_idx_i == AUXW'(g)) begin
        base_q <= aux_base_i;
        fld_q  <= aux_fld_i;
      end
    end
    assign aux_base_o[g] = base_q;
    assign aux_fld_o[g]  = fld_q;
  end
endmodule

// File: rtl/ob_win_bank.sv
`timescale 1ns/1ps
module ob_win_bank #(
  parameter int AW   = 64,
  parameter int N_OB = 4,
  localparam int IW  = $clog2(N_OB) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ob_wr_i,
  input  logic [IW-1:0]   ob_idx_i,
  input  logic [AW-1:0]   ob_cpu_start_i,
  input  logic [AW-1:0]   ob_cpu_end_i,
  input  logic [AW-1:0]   ob_pci_start_i,
  input  logic [AW-1:0]   lk_addr_i,
  output logic [N_OB-1:0] ob_hit_o,
  output logic [AW-1:0]   ob_xlat_o [N_OB],
  output logic            ob_ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ob_ovf_o <= 1'b0;
    else if (ob_wr_i && ob_idx_i >= IW'(N_OB))     ob_ovf_o <= 1'b1;
  end

  for (genvar g = 0; g < N_OB; g++) begin : g_win
    logic [AW-1:0] start_q, len_q, pci_q, rel;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_q <= '0;
        len_q   <= '0;
        pci_q   <= '0;
      end else if (ob_wr_i && ob_idx_i == IW'(g)) begin
        start_q <= ob_cpu_start_i;
        len_q   <= ob_cpu_end_i - ob_cpu_start_i + AW'(1);
        pci_q   <= ob_pci_start_i;
      end
    end
    assign rel          = lk_addr_i - start_q;
    assign ob_hit_o[g]  = (len_q != '0) && (lk_addr_i >= start_q) && (rel < len_q);
    assign ob_xlat_o[g] = rel + pci_q;
  end
endmodule

// File: rtl/lookup_stage.sv
`timescale 1ns/1ps
module lookup_stage #(
  parameter int AW       = 64,
  parameter int N_OB     = 4,
  parameter int N_AUX    = 2,
  parameter int SFW      = 6,
  parameter int MIN_LOG2 = 15,
  localparam int LW      = $clog2(AW + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            addr_vld_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [N_OB-1:0] ob_hit_i,
  input  logic [AW-1:0]   ob_xlat_i [N_OB],
  input  logic            vp_en_i,
  input  logic [AW-1:0]   vp_base_i,
  input  logic [LW-1:0]   vp_log2_i,
  input  logic [AW-1:0]   aux_base_i [N_AUX],
  input  logic [SFW-1:0]  aux_fld_i  [N_AUX],
  output logic            res_vld_o,
  output logic            res_hit_o,
  output logic            res_err_o,
  output logic            res_dir_o,
  output logic [AW-1:0]   res_xlat_o
);
  import addr_win_pkg::*;

  logic [AW-1:0] vp_mask;
  logic          vp_hit;
  logic [AW-1:0] aux_mask [N_AUX];
  logic [N_AUX-1:0] aux_hit;
  logic          hit_d;
  dir_e          dir_d;
  logic [AW-1:0] xlat_d;

  always_comb begin
    vp_mask = ~((AW'(1) << vp_log2_i) - AW'(1));
    vp_hit  = vp_en_i && (((addr_i ^ vp_base_i) & vp_mask) == '0);
    for (int i = 0; i < N_AUX; i++) begin
      int k;
      k = int'(aux_fld_i[i]) + MIN_LOG2;
      aux_mask[i] = (k >= AW) ? '0 : ~((AW'(1) << k) - AW'(1));
      aux_hit[i]  = (aux_fld_i[i] != '0) && (((addr_i ^ aux_base_i[i]) & aux_mask[i]) == '0);
    end
  end

  // priority: outbound (low index first) > viewport > auxiliary
  always_comb begin
    hit_d  = 1'b0;
    dir_d  = DIR_UP;
    xlat_d = '0;
    for (int i = N_AUX - 1; i >= 0; i--)
      if (aux_hit[i]) begin
        hit_d  = 1'b1;
        dir_d  = DIR_UP;
        xlat_d = addr_i & ~aux_mask[i];
      end
    if (vp_hit) begin
      hit_d  = 1'b1;
      dir_d  = DIR_UP;
      xlat_d = addr_i - vp_base_i;
    end
    for (int i = N_OB - 1; i >= 0; i--)
      if (ob_hit_i[i]) begin
        hit_d  = 1'b1;
        dir_d  = DIR_DN;
        xlat_d = ob_xlat_i[i];
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o  <= 1'b0;
      res_hit_o  <= 1'b0;
      res_err_o  <= 1'b0;
      res_dir_o  <= 1'b0;
      res_xlat_o <= '0;
    end else begin
      res_vld_o  <= addr_vld_i;
      res_hit_o  <= addr_vld_i && hit_d;
      res_err_o  <= addr_vld_i && !hit_d;
      res_dir_o  <= addr_vld_i && hit_d && (dir_d == DIR_DN);
      res_xlat_o <= (addr_vld_i && hit_d) ? xlat_d : '0;
    end
  end
endmodule

// File: rtl/pcie_addr_window_dec.sv
`timescale 1ns/1ps
module pcie_addr_window_dec #(
  parameter int AW       = 64,
  parameter int N_OB     = 4,
  parameter int N_AUX    = 2,
  parameter int SFW      = 6,
  parameter int MIN_LOG2 = 15,
  localparam int IW      = $clog2(N_OB) + 1,
  localparam int AUXW    = (N_AUX > 1) ? $clog2(N_AUX) : 1,
  localparam int LW      = $clog2(AW + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ib_wr_i,
  input  logic [AW-1:0]   ib_base_i,
  input  logic [AW-1:0]   ib_span_i,
  input  logic            aux_wr_i,
  input  logic [AUXW-1:0] aux_idx_i,
  input  logic [AW-1:0]   aux_base_i,
  input  logic [SFW-1:0]  aux_fld_i,
  input  logic            ob_wr_i,
  input  logic [IW-1:0]   ob_idx_i,
  input  logic [AW-1:0]   ob_cpu_start_i,
  input  logic [AW-1:0]   ob_cpu_end_i,
  input  logic [AW-1:0]   ob_pci_start_i,
  input  logic            addr_vld_i,
  input  logic [AW-1:0]   addr_i,
  output logic            res_vld_o,
  output logic            res_hit_o,
  output logic            res_err_o,
  output logic            res_dir_o,
  output logic [AW-1:0]   res_xlat_o,
  output logic            ib_cfg_err_o,
  output logic [SFW-1:0]  ib_size_fld_o,
  output logic            ob_ovf_o
);
  logic            vp_en;
  logic [AW-1:0]   vp_base;
  logic [LW-1:0]   vp_log2;
  logic [AW-1:0]   aux_base [N_AUX];
  logic [SFW-1:0]  aux_fld  [N_AUX];
  logic [N_OB-1:0] ob_hit;
  logic [AW-1:0]   ob_xlat  [N_OB];

  vp_cfg #(.AW(AW), .SFW(SFW), .MIN_LOG2(MIN_LOG2), .N_AUX(N_AUX)) u_vp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ib_wr_i    (ib_wr_i),
    .ib_base_i  (ib_base_i),
    .ib_span_i  (ib_span_i),
    .aux_wr_i   (aux_wr_i),
    .aux_idx_i  (aux_idx_i),
    .aux_base_i (aux_base_i),
    .aux_fld_i  (aux_fld_i),
    .vp_en_o    (vp_en),
    .vp_base_o  (vp_base),
    .vp_log2_o  (vp_log2),
    .cfg_err_o  (ib_cfg_err_o),
    .size_fld_o (ib_size_fld_o),
    .aux_base_o (aux_base),
    .aux_fld_o  (aux_fld)
  );

  ob_win_bank #(.AW(AW), .N_OB(N_OB)) u_ob (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ob_wr_i        (ob_wr_i),
    .ob_idx_i       (ob_idx_i),
    .ob_cpu_start_i (ob_cpu_start_i),
    .ob_cpu_end_i   (ob_cpu_end_i),
    .ob_pci_start_i (ob_pci_start_i),
    .lk_addr_i      (addr_i),
    .ob_hit_o       (ob_hit),
    .ob_xlat_o      (ob_xlat),
    .ob_ovf_o       (ob_ovf_o)
  );

  lookup_stage #(.AW(AW), .N_OB(N_OB), .N_AUX(N_AUX), .SFW(SFW), .MIN_LOG2(MIN_LOG2)) u_lk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_vld_i (addr_vld_i),
    .addr_i     (addr_i),
    .ob_hit_i   (ob_hit),
    .ob_xlat_i  (ob_xlat),
    .vp_en_i    (vp_en),
    .vp_base_i  (vp_base),
    .vp_log2_i  (vp_log2),
    .aux_base_i (aux_base),
    .aux_fld_i  (aux_fld),
    .res_vld_o  (res_vld_o),
    .res_hit_o  (res_hit_o),
    .res_err_o  (res_err_o),
    .res_dir_o  (res_dir_o),
    .res_xlat_o (res_xlat_o)
  );
endmodule

// File: rtl/pcie_addr_window_dec_chk.sv
`timescale 1ns/1ps
module pcie_addr_window_dec_chk #(
  parameter int AW   = 64,
  parameter int N_OB = 4,
  parameter int SFW  = 6,
  localparam int IW  = $clog2(N_OB) + 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ob_wr_i,
  input logic [IW-1:0]  ob_idx_i,
  input logic           addr_vld_i,
  input logic           res_vld_o,
  input logic           res_hit_o,
  input logic           res_err_o,
  input logic           res_dir_o,
  input logic [AW-1:0]  res_xlat_o,
  input logic           ib_cfg_err_o,
  input logic [SFW-1:0] ib_size_fld_o,
  input logic           ob_ovf_o
);
  // R1
  res_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_i |=> res_vld_o);
  // R1
  res_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_vld_i |=> !res_vld_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_o |-> (!res_hit_o && !res_err_o && !res_dir_o && res_xlat_o == '0));
  // R12
  hit_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> (res_hit_o != res_err_o));
  // R12
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_err_o |-> (!res_dir_o && res_xlat_o == '0));
  // R6
  err_fld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ib_cfg_err_o |-> (ib_size_fld_o == SFW'(15)));
  // R11
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ob_ovf_o |=> ob_ovf_o);
  // R11
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ob_wr_i && ob_idx_i >= IW'(N_OB)) |=> ob_ovf_o);
endmodule

bind pcie_addr_window_dec pcie_addr_window_dec_chk #(.AW(AW), .N_OB(N_OB), .SFW(SFW)) u_chk (.*);

// File: tb/sim_pcie_addr_window_dec.sv
`timescale 1ns/1ps
module sim_pcie_addr_window_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ib_wr = 1'b0, aux_wr = 1'b0, ob_wr = 1'b0, addr_vld = 1'b0;
  logic [63:0] ib_base = '0, ib_span = '0, aux_base = '0, ob_cs = '0, ob_ce = '0, ob_ps = '0, addr = '0;
  logic        aux_idx = 1'b0;
  logic [5:0]  aux_fld = '0;
  logic [2:0]  ob_idx = '0;
  logic        res_vld, res_hit, res_err, res_dir, cfg_err, ovf;
  logic [63:0] res_xlat;
  logic [5:0]  size_fld;
  int          total = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pcie_addr_window_dec u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ib_wr_i(ib_wr), .ib_base_i(ib_base), .ib_span_i(ib_span),
    .aux_wr_i(aux_wr), .aux_idx_i(aux_idx), .aux_base_i(aux_base), .aux_fld_i(aux_fld),
    .ob_wr_i(ob_wr), .ob_idx_i(ob_idx), .ob_cpu_start_i(ob_cs), .ob_cpu_end_i(ob_ce),
    .ob_pci_start_i(ob_ps), .addr_vld_i(addr_vld), .addr_i(addr),
    .res_vld_o(res_vld), .res_hit_o(res_hit), .res_err_o(res_err), .res_dir_o(res_dir),
    .res_xlat_o(res_xlat), .ib_cfg_err_o(cfg_err), .ib_size_fld_o(size_fld), .ob_ovf_o(ovf)
  );

  typedef struct packed {
    logic [63:0] a;
    logic        h;
    logic        d;
    logic [63:0] x;
    logic [7:0]  r;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{64'h0000_0000_C000_1234, 1'b1, 1'b1, 64'h0000_0000_6000_1234, 8'd4},  // R4 R2 inside viewport too
    '{64'h0000_0000_C0FF_FFFF, 1'b1, 1'b1, 64'h0000_0000_60FF_FFFF, 8'd3},  // R3 end of window 0
    '{64'h0000_0000_C080_0000, 1'b1, 1'b1, 64'h0000_0000_6080_0000, 8'd3},  // R3 overlap, window 0 wins
    '{64'h0000_0000_C100_0010, 1'b1, 1'b1, 64'h0000_0000_8080_0010, 8'd2},  // R2 window 1
    '{64'h0000_0000_C200_0000, 1'b1, 1'b0, 64'h0000_0000_C200_0000, 8'd5},  // R5 past window 1
    '{64'h0000_0006_0000_FFFF, 1'b1, 1'b1, 64'h0000_0000_0001_0FFF, 8'd2},  // R2 inclusive end
    '{64'h0000_0006_0001_0000, 1'b0, 1'b0, 64'h0, 8'd12},                   // R12
    '{64'h0000_0000_1234_5678, 1'b1, 1'b0, 64'h0000_0000_1234_5678, 8'd5},  // R5
    '{64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0, 64'h0000_0000_FFFF_FFFF, 8'd5},  // R5 top of viewport
    '{64'h0000_0001_0000_0000, 1'b0, 1'b0, 64'h0, 8'd5},                    // R5 just past viewport
    '{64'h0000_0007_0000_0000, 1'b0, 1'b0, 64'h0, 8'd13},                   // R13 zero-length window
    '{64'h0000_0008_0000_FFFF, 1'b1, 1'b0, 64'h0000_0000_0000_FFFF, 8'd10}, // R10 aux 0
    '{64'h0000_0008_0001_0000, 1'b0, 1'b0, 64'h0, 8'd10},                   // R10 past aux 0
    '{64'h0000_0009_0000_0000, 1'b0, 1'b0, 64'h0, 8'd10},                   // R10 aux 1 off
    '{64'h0000_0000_BFFF_FFFF, 1'b1, 1'b0, 64'h0000_0000_BFFF_FFFF, 8'd5}   // R5
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [63:0] a);
    @(negedge clk);
    addr_vld = 1'b1;
    addr     = a;
    @(negedge clk);
    addr_vld = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic h, input logic d, input logic [63:0] x);
    chk(req, "vld", {63'd0, res_vld}, 64'd1);
    chk(req, "hit", {63'd0, res_hit}, {63'd0, h});
    chk(req, "err", {63'd0, res_err}, {63'd0, !h});
    chk(req, "dir", {63'd0, res_dir}, {63'd0, d});
    chk(req, "xlat", res_xlat, x);
  endtask

  task automatic ib_cfg(input logic [63:0] b, input logic [63:0] s);
    @(negedge clk);
    ib_wr = 1'b1; ib_base = b; ib_span = s;
    @(negedge clk);
    ib_wr = 1'b0;
  endtask

  task automatic ob_cfg(input logic [2:0] i, input logic [63:0] cs, input logic [63:0] ce, input logic [63:0] ps);
    @(negedge clk);
    ob_wr = 1'b1; ob_idx = i; ob_cs = cs; ob_ce = ce; ob_ps = ps;
    @(negedge clk);
    ob_wr = 1'b0;
  endtask

  task automatic aux_cfg(input logic i, input logic [63:0] b, input logic [5:0] f);
    @(negedge clk);
    aux_wr = 1'b1; aux_idx = i; aux_base = b; aux_fld = f;
    @(negedge clk);
    aux_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1", "vld after reset", {63'd0, res_vld}, 64'd0);
    chk("R6", "fld after reset", {58'd0, size_fld}, 64'hF);
    chk("R7", "cfg_err after reset", {63'd0, cfg_err}, 64'd0);
    chk("R11", "ovf after reset", {63'd0, ovf}, 64'd0);
    lookup(64'h1000);
    expect_res("R12", 1'b0, 1'b0, 64'h0);
    lookup(64'h0000_0008_0000_0000);
    expect_res("R10", 1'b0, 1'b0, 64'h0);
    @(negedge clk);
    chk("R1", "vld drops", {63'd0, res_vld}, 64'd0);

    // configuration for the table
    ib_cfg(64'h0, 64'hBFFF_FFFF);
    chk("R6", "fld 4G", {58'd0, size_fld}, 64'd17);
    chk("R5", "cfg_err good", {63'd0, cfg_err}, 64'd0);
    ob_cfg(3'd0, 64'hC000_0000, 64'hC0FF_FFFF, 64'h6000_0000);
    ob_cfg(3'd1, 64'hC080_0000, 64'hC1FF_FFFF, 64'h8000_0000);
    ob_cfg(3'd2, 64'h6_0000_0000, 64'h6_0000_FFFF, 64'h1000);
    ob_cfg(3'd3, 64'h7_0000_0000, 64'h6_FFFF_FFFF, 64'h2000);
    aux_cfg(1'b0, 64'h8_0000_0000, 6'd1);
    aux_cfg(1'b1, 64'h9_0000_0000, 6'd0);
    chk("R11", "ovf legal writes", {63'd0, ovf}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i].a);
      expect_res($sformatf("R%0d vec%0d", VEC[i].r, i), VEC[i].h, VEC[i].d, VEC[i].x);
    end

    // R11 out-of-range index ignored
    ob_cfg(3'd4, 64'hC000_0000, 64'hC0FF_FFFF, 64'hDEAD_0000);
    chk("R11", "ovf set", {63'd0, ovf}, 64'd1);
    lookup(64'hC000_1234);
    expect_res("R11", 1'b1, 1'b1, 64'h6000_1234);
    chk("R11", "ovf sticky", {63'd0, ovf}, 64'd1);

    // R7 size overflows to zero
    ib_cfg(64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R7", "cfg_err zero size", {63'd0, cfg_err}, 64'd1);
    chk("R6", "fld on error", {58'd0, size_fld}, 64'hF);
    lookup(64'h1234_5678);
    expect_res("R7", 1'b0, 1'b0, 64'h0);
    // R7 too small
    ib_cfg(64'h0, 64'h1000);
    chk("R7", "cfg_err small", {63'd0, cfg_err}, 64'd1);
    // R8 misaligned
    ib_cfg(64'h1000, 64'hFFFF);
    chk("R8", "cfg_err misalign", {63'd0, cfg_err}, 64'd1);
    chk("R6", "fld misalign", {58'd0, size_fld}, 64'hF);
    // R9 forbidden placement
    ib_cfg(64'hC000_0000, 64'h0FFF_FFFF);
    chk("R9", "cfg_err forbidden", {63'd0, cfg_err}, 64'd1);
    // R9 exactly 2G allowed
    ib_cfg(64'h8000_0000, 64'h7FFF_FFFF);
    chk("R9", "cfg_err 2G", {63'd0, cfg_err}, 64'd0);
    chk("R6", "fld 2G", {58'd0, size_fld}, 64'd16);
    lookup(64'h8000_0010);
    expect_res("R9", 1'b1, 1'b0, 64'h10);
    lookup(64'h7FFF_FFFF);
    expect_res("R5", 1'b0, 1'b0, 64'h0);
    // R9 exactly 4G allowed
    ib_cfg(64'h1_0000_0000, 64'hFFFF_FFFF);
    chk("R9", "cfg_err 4G", {63'd0, cfg_err}, 64'd0);
    chk("R6", "fld 4G base", {58'd0, size_fld}, 64'd17);
    lookup(64'h1_0000_0004);
    expect_res("R9", 1'b1, 1'b0, 64'h4);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule